// File: doc/BRIEF.md
# Serial Peripheral Master with Register Port

This block is a single-word SPI master that software drives through a small
register port. Software sets the clock polarity, the clock phase, the bit order,
an internal loopback path, the word length and a two-range SCK divider in a
configuration register. It then writes one word at a time into the transmit
register. Each word is shifted out on `mosi` while `miso` is shifted in. The
received word is placed in the receive register in a fixed lane of a 32-bit
value, and that lane depends on the bit order and the word length.

One holding slot sits in front of the shifter, so software can queue a second word
while the first one is in flight. The two status flags are "receive word ready" and
"transmit slot free". They are sticky and software clears them by writing ones to
the flag register. A mask register selects which flags raise `irq`. Slave-select
outputs follow a register that comes out of reset with every line deselected. A
read-only capability word reports the maximum word length and the number of select
lines.

Top module: `spim_top`

## Requirements
- R1: After reset the configuration register reads 0, the flag register reads 2 (slot-free bit 1 set, ready bit 0 clear), `irq` is 0, `sck` is 0, and every `ssN` line is 1.
- R2: The register at address 0 holds the configuration. Bit 9 selects the slow range and bits 13:10 hold the divide value D. The SCK half period is 2×(D+1) system clocks with bit 9 clear and 32×(D+1) system clocks with bit 9 set. A word of N bits produces exactly 2N SCK transitions.
- R3: Bit 2 sets the SCK idle level. With bit 1 (phase) clear, every bit is valid on `mosi` at the first edge of each SCK period. With bit 1 set, every bit is valid at the second edge.
- R4: Bit 3 set selects MSB-first, and the N-bit word is then taken from bits 31 down to 32−N of the transmit register. Bit 3 clear selects LSB-first, and the word is then taken from bits N−1:0 with bit 0 sent first.
- R5: For MSB-first words of 16 bits or fewer, the received word is placed in the receive register with its LSB at bit 16, and all other bits read 0.
- R6: For LSB-first words of 16 bits or fewer, the received word is placed with its MSB at bit 15, and all other bits read 0. A 32-bit word is stored unshifted in either order.
- R7: Bits 8:5 hold the word length minus one, and the value 0 selects a 32-bit word.
- R8: With bit 4 set, the input is taken from the outgoing serial bit. With bit 4 clear, the input is taken from `miso`.
- R9: The ready flag (bit 0 of the flag register at address 1) sets exactly 2N×(H)+2 cycles after the transmit write, where H is the half period. Writing 1 to bit 0 clears the flag, and so does a read of the receive register at address 4.
- R10: A write to the transmit register at address 3 clears the slot-free flag (bit 1). The flag sets again when the shifter takes that word. A word written while another is in flight is sent right after it.
- R11: `irq` is the OR of the flags ANDed with the mask register at address 2, which uses the same bit positions as the flag register.
- R12: Bit 0 of the configuration register enables the shifter. Writes made while the shifter is enabled are stored but do not take effect until bit 0 has been cleared and set again.
- R13: `ssN` follows the low bits of the register at address 5. The capability register at address 6 reads 0x001F0104: the line count in bits 7:0, a "selects present" bit at 8, and maximum length minus one in bits 20:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects only) |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | NSEL | Slave selects, active low |
| irq | output | 1 | Masked interrupt |

## Verification
A transmit write lands in the holding slot on the clock edge that takes it. The shifter loads that word one edge later. Each SCK transition then follows H cycles after the previous one, and the ready flag sets one edge after the last transition. That places it at exactly 2N×H+2 edges after the write, so the bench samples the flag at negative clock edges one cycle before that edge and again on it. Register reads are combinational and are sampled 1 ns after a negative edge. A monitor counts SCK transitions, measures the gap between them, and captures `mosi` on the sampling edge of the selected phase.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam int PM_W   = 4;
  localparam int LEN_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE  = 3'd0,
    A_EVENT = 3'd1,
    A_MASK  = 3'd2,
    A_TXD   = 3'd3,
    A_RXD   = 3'd4,
    A_SSEL  = 3'd5,
    A_CAP   = 3'd6
  } regAddr_e;

  localparam int B_EN    = 0;
  localparam int B_CPHA  = 1;
  localparam int B_CPOL  = 2;
  localparam int B_MSB   = 3;
  localparam int B_LOOP  = 4;
  localparam int B_LEN   = 5;
  localparam int B_DIV16 = 9;
  localparam int B_PM    = 10;

  localparam int EV_NE = 0;
  localparam int EV_NF = 1;

  typedef struct packed {
    logic             cpha;
    logic             cpol;
    logic             msbFirst;
    logic             loop;
    logic [LEN_W-1:0] lenCode;
    logic             div16;
    logic [PM_W-1:0]  pm;
  } spiCfg_t;

  typedef struct packed {
    logic load;
    logic abort;
  } spiStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NSEL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  logic              dpBusy,
  input  logic              dpDone,
  input  logic [WORD_W-1:0] dpRxWord,
  output spiCfg_t           liveCfg,
  output spiStrobe_t        strobe,
  output logic [WORD_W-1:0] holdWord,
  output logic [NSEL-1:0]   ssN,
  output logic              irq,
  output logic              evNe,
  output logic              evNf,
  output logic [1:0]        maskBits
);
  localparam logic [WORD_W-1:0] CAP_WORD =
    (WORD_W'(WORD_W - 1) << 16) | (WORD_W'(1) << 8) | WORD_W'(NSEL);

  logic [WORD_W-1:0] modeReg;
  logic [NSEL-1:0]   selReg;
  logic              holdFull;
  logic              liveEn;

  logic wrMode, wrEvent, wrMask, wrTx, wrSel, rdRx;
  assign wrMode  = regWr && (regAddr == A_MODE);
  assign wrEvent = regWr && (regAddr == A_EVENT);
  assign wrMask  = regWr && (regAddr == A_MASK);
  assign wrTx    = regWr && (regAddr == A_TXD);
  assign wrSel   = regWr && (regAddr == A_SSEL);
  assign rdRx    = regRd && (regAddr == A_RXD);

  assign strobe.abort = wrMode && !regWdata[B_EN];
  assign strobe.load  = liveEn && holdFull && !dpBusy && !strobe.abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg  <= '0;
      liveEn   <= 1'b0;
      liveCfg  <= '0;
      holdFull <= 1'b0;
      holdWord <= '0;
      evNe     <= 1'b0;
      evNf     <= 1'b1;
      maskBits <= '0;
      selReg   <= '1;
    end else begin
      if (wrMode) begin
        modeReg <= regWdata;
        liveEn  <= regWdata[B_EN];
        if (!liveEn && regWdata[B_EN]) begin
          liveCfg.cpha     <= regWdata[B_CPHA];
          liveCfg.cpol     <= regWdata[B_CPOL];
          liveCfg.msbFirst <= regWdata[B_MSB];
          liveCfg.loop     <= regWdata[B_LOOP];
          liveCfg.lenCode  <= regWdata[B_LEN +: LEN_W];
          liveCfg.div16    <= regWdata[B_DIV16];
          liveCfg.pm       <= regWdata[B_PM +: PM_W];
        end
      end
      if (wrMask) maskBits <= regWdata[1:0];
      if (wrSel)  selReg   <= regWdata[NSEL-1:0];
      if (wrEvent) begin
        if (regWdata[EV_NE]) evNe <= 1'b0;
        if (regWdata[EV_NF]) evNf <= 1'b0;
      end
      if (rdRx) evNe <= 1'b0;
      if (strobe.load) begin
        holdFull <= 1'b0;
        evNf     <= 1'b1;
      end
      if (wrTx) begin
        holdFull <= 1'b1;
        holdWord <= regWdata;
        evNf     <= 1'b0;
      end
      if (dpDone) evNe <= 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      A_MODE:  regRdata = modeReg;
      A_EVENT: regRdata = WORD_W'({evNf, evNe});
      A_MASK:  regRdata = WORD_W'(maskBits);
      A_TXD:   regRdata = holdWord;
      A_RXD:   regRdata = dpRxWord;
      A_SSEL:  regRdata = WORD_W'(selReg);
      A_CAP:   regRdata = CAP_WORD;
      default: regRdata = '0;
    endcase
  end

  assign ssN = selReg;
  assign irq = |({evNf, evNe} & maskBits);
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  spiCfg_t           cfg,
  input  spiStrobe_t        strobe,
  input  logic [WORD_W-1:0] txWord,
  input  logic              misoIn,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rxWord
);
  localparam int HCNT_W = $clog2(32 * (1 << PM_W)) + 1;
  localparam int NB_W   = $clog2(WORD_W) + 1;
  localparam int ECNT_W = NB_W + 1;

  logic [WORD_W-1:0] sh, shNext, lenMask, rxAligned;
  logic [HCNT_W-1:0] halfCnt, halfLim;
  logic [ECNT_W-1:0] edgeCnt, edgeLast;
  logic [NB_W-1:0]   nBits;
  logic sckInt, mosiReg, rxBit, tick, leading, inBit, misoEff;

  function automatic logic outBit(input logic [WORD_W-1:0] w, input logic msb);
    return msb ? w[WORD_W-1] : w[0];
  endfunction

  assign halfLim  = ((HCNT_W'(cfg.pm) + HCNT_W'(1)) << (cfg.div16 ? 5 : 1)) - HCNT_W'(1);
  assign nBits    = (cfg.lenCode == '0) ? NB_W'(WORD_W) : NB_W'(cfg.lenCode) + NB_W'(1);
  assign edgeLast = ECNT_W'({nBits, 1'b0}) - ECNT_W'(1);
  assign tick     = busy && (halfCnt == halfLim);
  assign leading  = ~edgeCnt[0];
  assign misoEff  = cfg.loop ? mosiReg : misoIn;
  assign inBit    = cfg.cpha ? misoEff : rxBit;
  assign shNext   = cfg.msbFirst ? {sh[WORD_W-2:0], inBit} : {inBit, sh[WORD_W-1:1]};
  assign lenMask  = (nBits == NB_W'(WORD_W)) ? '1 : ((WORD_W'(1) << nBits) - WORD_W'(1));

  always_comb begin
    if (nBits == NB_W'(WORD_W))
      rxAligned = shNext;
    else if (cfg.msbFirst)
      rxAligned = (shNext & lenMask) << 16;
    else
      rxAligned = (shNext >> 16) & (lenMask << (NB_W'(16) - nBits));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; halfCnt <= '0; edgeCnt <= '0;
      sckInt <= 1'b0; mosiReg <= 1'b0; rxBit <= 1'b0;
      busy <= 1'b0; done <= 1'b0; rxWord <= '0;
    end else begin
      done <= 1'b0;
      if (strobe.abort) begin
        busy   <= 1'b0;
        sckInt <= 1'b0;
      end else if (strobe.load) begin
        busy    <= 1'b1;
        sh      <= txWord;
        halfCnt <= '0;
        edgeCnt <= '0;
        sckInt  <= 1'b0;
        mosiReg <= outBit(txWord, cfg.msbFirst);
      end else if (tick) begin
        halfCnt <= '0;
        sckInt  <= ~sckInt;
        edgeCnt <= edgeCnt + ECNT_W'(1);
        if (leading) begin
          if (!cfg.cpha) rxBit <= misoEff;
          else           mosiReg <= outBit(sh, cfg.msbFirst);
        end else begin
          sh <= shNext;
          if (!cfg.cpha) mosiReg <= outBit(shNext, cfg.msbFirst);
          if (edgeCnt == edgeLast) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            rxWord <= rxAligned;
          end
        end
      end else if (busy) begin
        halfCnt <= halfCnt + HCNT_W'(1);
      end
    end
  end

  assign sck  = sckInt ^ cfg.cpol;
  assign mosi = mosiReg;
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NSEL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NSEL-1:0]   ssN,
  output logic              irq
);
  spiCfg_t           liveCfg;
  spiStrobe_t        strobe;
  logic [WORD_W-1:0] holdWord, dpRxWord;
  logic              dpBusy, dpDone, evNe, evNf;
  logic [1:0]        maskBits;

  spim_ctrl #(.NSEL(NSEL)) uCtrl (
    .clk(clk), .rst(rst), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dpBusy(dpBusy), .dpDone(dpDone),
    .dpRxWord(dpRxWord), .liveCfg(liveCfg), .strobe(strobe), .holdWord(holdWord),
    .ssN(ssN), .irq(irq), .evNe(evNe), .evNf(evNf), .maskBits(maskBits)
  );

  spim_datapath uDp (
    .clk(clk), .rst(rst), .cfg(liveCfg), .strobe(strobe), .txWord(holdWord),
    .misoIn(miso), .sck(sck), .mosi(mosi), .busy(dpBusy), .done(dpDone),
    .rxWord(dpRxWord)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk
  import spim_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [1:0]        maskBits,
  input logic              sck,
  input logic              cfgCpol,
  input logic              dpBusy,
  input logic              dpDone,
  input logic              evNe,
  input logic              evNf,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              load
);
  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (maskBits == 2'b00) |-> !irq);

  // R9
  ne_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    dpDone |=> evNe);

  // R10
  nf_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (regWr && (regAddr == A_TXD)) |=> !evNf);

  // R10
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !dpBusy);

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dpBusy |-> (sck == cfgCpol));
endmodule

bind spim_top spim_chk uChk (
  .clk(clk), .rst(rst), .irq(irq), .maskBits(maskBits), .sck(sck),
  .cfgCpol(liveCfg.cpol), .dpBusy(dpBusy), .dpDone(dpDone), .evNe(evNe),
  .evNf(evNf), .regWr(regWr), .regAddr(regAddr), .load(strobe.load)
);

// File: tb/sim_spim_top.sv
module sim_spim_top;
  import spim_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWr = 1'b0, regRd = 1'b0, miso = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        sck, mosi, irq;
  logic [3:0]  ssN;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  spim_top #(.NSEL(4)) u0 (
    .clk(clk), .rst(rst), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ssN(ssN), .irq(irq)
  );

  always #2 clk = ~clk;

  // serial monitor
  logic        prevSck = 1'b0;
  int          toggleTotal = 0, gapCnt = 0, lastGap = 0;
  logic [31:0] capBits = '0;
  bit          monCpha = 0, monCpol = 0;
  always @(negedge clk) begin
    if (sck !== prevSck) begin
      toggleTotal++;
      lastGap = gapCnt;
      gapCnt  = 1;
      if ((sck != monCpol) == !monCpha) capBits = {capBits[30:0], mosi};
    end else begin
      gapCnt++;
    end
    prevSck = sck;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regPeek(logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic [31:0] modeWord(bit en, bit cpha, bit cpol, bit msb, bit loop,
                                           logic [3:0] len, bit div16, logic [3:0] pm);
    return {18'b0, pm, div16, len, loop, msb, cpol, cpha, en};
  endfunction

  task automatic runWord(string tag, bit cpha, bit cpol, bit msb, bit loop,
                         logic [3:0] len, bit div16, logic [3:0] pm,
                         logic [31:0] tx, logic [31:0] exp);
    int n = (len == 0) ? 32 : int'(len) + 1;
    int h = (div16 ? 32 : 2) * (int'(pm) + 1);
    int base;
    logic [31:0] v, expCap, m;
    monCpha = cpha; monCpol = cpol;
    regWrite(A_MODE, modeWord(0, cpha, cpol, msb, loop, len, div16, pm));
    regWrite(A_MODE, modeWord(1, cpha, cpol, msb, loop, len, div16, pm));
    regWrite(A_EVENT, 32'h1);
    base = toggleTotal;
    regWrite(A_TXD, tx);
    repeat (2 * n * h + 1) @(negedge clk);
    regPeek(A_EVENT, v);
    check({tag, " R9 ready not yet"}, 32'(v[0]), 32'h0);
    @(negedge clk);
    regPeek(A_EVENT, v);
    check({tag, " R9 ready due"}, 32'(v[0]), 32'h1);
    regPeek(A_RXD, v);
    check({tag, " R5 R6 R7 R8 rx lane"}, v, exp);
    check({tag, " R2 transitions"}, 32'(toggleTotal - base), 32'(2 * n));
    check({tag, " R2 half period"}, 32'(lastGap), 32'(h));
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    expCap = '0;
    for (int i = 0; i < n; i++)
      expCap = {expCap[30:0], msb ? tx[31 - i] : tx[i]};
    check({tag, " R3 R4 mosi bits"}, capBits & m, expCap & m);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    regPeek(A_MODE, v);  check("R1 mode", v, 32'h0);
    regPeek(A_EVENT, v); check("R1 flags", v, 32'h2);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 sck", 32'(sck), 32'h0);
    check("R1 ssN", 32'(ssN), 32'hF);
    regPeek(A_CAP, v);   check("R13 cap", v, 32'h001F_0104);
  endtask

  task automatic t_select();
    regWrite(A_SSEL, 32'hE);
    @(negedge clk);
    check("R13 ssN low bit", 32'(ssN), 32'hE);
    regWrite(A_SSEL, 32'hF);
  endtask

  task automatic t_words();
    runWord("w8",   0, 0, 1, 1, 4'd7,  0, 4'd0, 32'hA512_3456, 32'h00A5_0000);
    runWord("w12",  1, 1, 0, 1, 4'd11, 0, 4'd2, 32'hFFFF_0ABC, 32'h0000_ABC0);
    runWord("w32",  0, 1, 1, 1, 4'd0,  0, 4'd0, 32'h89AB_CDEF, 32'h89AB_CDEF);
    runWord("w32l", 1, 0, 0, 1, 4'd0,  0, 4'd1, 32'h1357_9BDF, 32'h1357_9BDF);
    runWord("w4",   1, 0, 1, 1, 4'd3,  1, 4'd1, 32'hC000_0000, 32'h000C_0000);
    miso = 1'b1;
    runWord("m5",   0, 0, 1, 0, 4'd4,  0, 4'd0, 32'h0000_0000, 32'h001F_0000);
    runWord("m16",  1, 0, 0, 0, 4'd15, 0, 4'd0, 32'h0000_0000, 32'h0000_FFFF);
    miso = 1'b0;
  endtask

  task automatic t_flags();
    logic [31:0] v;
    runWord("f8", 0, 0, 1, 1, 4'd7, 0, 4'd0, 32'h3C00_0000, 32'h003C_0000);
    regWrite(A_EVENT, 32'h1);
    regPeek(A_EVENT, v);
    check("R9 write-one clear", 32'(v[0]), 32'h0);
    regWrite(A_TXD, 32'h5A00_0000);
    repeat (40) @(negedge clk);
    regPeek(A_EVENT, v);
    check("R9 ready before read", 32'(v[0]), 32'h1);
    @(negedge clk);
    regRd = 1'b1; regAddr = A_RXD;
    @(negedge clk);
    regRd = 1'b0;
    regPeek(A_EVENT, v);
    check("R9 read clears", 32'(v[0]), 32'h0);
    regWrite(A_MASK, 32'h1);
    check("R11 masked ready", 32'(irq), 32'h0);
    regWrite(A_TXD, 32'h0100_0000);
    repeat (40) @(negedge clk);
    check("R11 irq on ready", 32'(irq), 32'h1);
    regWrite(A_EVENT, 32'h1);
    check("R11 irq cleared", 32'(irq), 32'h0);
    regWrite(A_MASK, 32'h2);
    check("R11 irq slot free", 32'(irq), 32'h1);
    regWrite(A_MASK, 32'h0);
  endtask

  task automatic t_backToBack();
    logic [31:0] v;
    int base;
    regWrite(A_EVENT, 32'h3);
    base = toggleTotal;
    regWrite(A_TXD, 32'h1100_0000);
    regWrite(A_TXD, 32'h2200_0000);
    regPeek(A_EVENT, v);
    check("R10 slot taken", 32'(v[1]), 32'h0);
    repeat (80) @(negedge clk);
    regPeek(A_EVENT, v);
    check("R10 slot free again", 32'(v[1]), 32'h1);
    regPeek(A_RXD, v);
    check("R10 second word", v, 32'h0022_0000);
    check("R10 two words sent", 32'(toggleTotal - base), 32'd32);
  endtask

  task automatic t_liveCfg();
    int base;
    regWrite(A_MODE, modeWord(1, 0, 0, 1, 1, 4'd15, 0, 4'd0));
    base = toggleTotal;
    regWrite(A_TXD, 32'h1234_0000);
    repeat (80) @(negedge clk);
    check("R12 enabled write ignored", 32'(toggleTotal - base), 32'd16);
    regWrite(A_MODE, modeWord(0, 0, 0, 1, 1, 4'd15, 0, 4'd0));
    regWrite(A_MODE, modeWord(1, 0, 0, 1, 1, 4'd15, 0, 4'd0));
    base = toggleTotal;
    regWrite(A_TXD, 32'h1234_0000);
    repeat (150) @(negedge clk);
    check("R12 re-enable applies", 32'(toggleTotal - base), 32'd32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_select();
    t_words();
    t_flags();
    t_backToBack();
    t_liveCfg();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule